// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit for a small 16-bit machine built around a four-entry register file, an ALU with a result accumulator, and a single memory port. It owns the program counter, the memory address register and the instruction register. Every instruction starts with a three-step fetch. The sequencer then walks a short fixed micro-sequence for that instruction class. During the sequence it drives the memory read and write strobes, the register-file read and write selects, the ALU function code, the accumulator capture strobe and the write-back source select.

The sequencer supports four instruction forms. Two are loads, one from an absolute address and one through a register. The other two are a store to an absolute address and a three-register ALU operation. The absolute forms take their address from the word that follows the instruction. Memory answers a read strobe one cycle later on the read-data bus. The datapath sits outside the block and follows the control outputs.

Top module: `seq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the program counter, the address register and the instruction register. The next cycle is the first fetch step, and it has no memory strobe and no register write.
- R2: Fetch takes three cycles. First, the address register gets the program counter and the counter increments. Second, a read strobe is issued at the address register. Third, the returned word is latched into the instruction register. The program counter only ever changes by +1 outside reset.
- R3: Instruction word layout: opcode in bits 15:12 (1 = absolute load, 2 = register-indirect load, 3 = absolute store, 4 = ALU), destination register in 11:10, first source in 9:8, second source in 7:6, and ALU function in 3:0.
- R4: An absolute load takes 8 cycles in total and advances the program counter by 2. It reads the address from the following word and writes the memory word at that address into the destination register, with the write-back source set to memory.
- R5: A register-indirect load takes 6 cycles and advances the program counter by 1. It first moves the first-source register into the address register, then reads memory and writes the word into the destination register.
- R6: An absolute store takes 7 cycles and advances the program counter by 2. It drives the first-source register onto the write-data bus with one write strobe at the address taken from the following word.
- R7: An ALU instruction takes 5 cycles. In one step it presents both source selects and the function code and pulses the capture strobe. In the next step it writes the captured result into the destination register, with the write-back source set to the ALU.
- R8: The register-file write enable is high for exactly one cycle in each load or ALU instruction. It is never high during fetch, a store or a no-operation.
- R9: The memory read and write strobes are one-cycle pulses and are never high together.
- R10: The data-capture strobe is high exactly in the cycle after each read strobe, which is the cycle in which read data is valid.
- R11: Any other opcode is a no-operation. It takes only the 3 fetch cycles and writes neither memory nor registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read strobe |
| rf_rdata_a | input | 16 | Register-file read port A data |
| mem_addr | output | 16 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| data_ld | output | 1 | Capture read data into the data register |
| rf_rd_a | output | 2 | Register-file read select A |
| rf_rd_b | output | 2 | Register-file read select B |
| rf_wr_sel | output | 2 | Register-file write select |
| rf_wr_en | output | 1 | Register-file write enable |
| wb_alu | output | 1 | Write-back source: 1 ALU result, 0 memory data |
| alu_fn | output | 4 | ALU function code |
| alu_capture | output | 1 | Capture ALU result into the accumulator |
| pc_out | output | 16 | Program counter |
| ir_out | output | 16 | Instruction register |

## Verification
Assertions check several per-cycle rules on every cycle: strobe exclusivity and pulse width, the data-capture strobe following each read by one cycle, single-cycle write enables whose source matches a preceding read or capture, program-counter steps of one, and the reset state. The bench scenarios are the only place where cycle counts per class, correct operand routing and architectural results show up. Those results are the register contents, the memory after stores and the program counter at each instruction boundary, compared against an instruction-level model that runs random mixed programs.

// File: rtl/seq_pkg.sv
// Shared definitions for the instruction sequencer.
// Assumes a 4-bit opcode at the top of the instruction word.
package seq_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_LDA = 4'h1;
    localparam logic [OP_W-1:0] OPC_LDI = 4'h2;
    localparam logic [OP_W-1:0] OPC_STA = 4'h3;
    localparam logic [OP_W-1:0] OPC_ALU = 4'h4;

    // Micro-steps: fetch, address-word fetch (shared by absolute forms),
    // load tail, store tail, indirect load, ALU.
    typedef enum logic [3:0] {
        S_F0, S_F1, S_F2,
        S_W0, S_W1, S_W2,
        S_L3, S_L4, S_S3,
        S_I0, S_I1, S_I2,
        S_X0, S_X1
    } step_t;

    typedef struct packed {
        logic pc_inc;
        logic ar_pc;
        logic ar_mem;
        logic ar_reg;
        logic ir_load;
        logic rd;
        logic wr;
        logic dr_load;
        logic rf_we;
        logic wb_alu;
        logic acc_cap;
        logic use_ra;
        logic use_rb;
    } ctl_t;
endpackage

// File: rtl/seq_fsm.sv
// Step register and next-step logic of the sequencer.
// Dispatches directly from the read-data bus in the last fetch step, so
// the opcode is decoded in the same cycle it is latched.
module seq_fsm
    import seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] fetch_op,
    input  logic [OP_W-1:0] ir_op,
    output step_t           step
);
    step_t nxt;

    // Next-step selection.
    always_comb begin
        nxt = S_F0;
        unique case (step)
            S_F0: nxt = S_F1;
            S_F1: nxt = S_F2;
            S_F2: begin
                if (fetch_op == OPC_LDA || fetch_op == OPC_STA) nxt = S_W0;
                else if (fetch_op == OPC_LDI)                   nxt = S_I0;
                else if (fetch_op == OPC_ALU)                   nxt = S_X0;
                else                                            nxt = S_F0;
            end
            S_W0: nxt = S_W1;
            S_W1: nxt = S_W2;
            S_W2: nxt = (ir_op == OPC_STA) ? S_S3 : S_L3;
            S_L3: nxt = S_L4;
            S_L4: nxt = S_F0;
            S_S3: nxt = S_F0;
            S_I0: nxt = S_I1;
            S_I1: nxt = S_I2;
            S_I2: nxt = S_F0;
            S_X0: nxt = S_X1;
            S_X1: nxt = S_F0;
            default: nxt = S_F0;
        endcase
    end

    // Step register with synchronous reset to the first fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= S_F0;
        else        step <= nxt;
    end
endmodule

// File: rtl/seq_decode.sv
// Turns the current step and instruction register into control strobes
// and register selects. Purely combinational; selects read zero when unused.
module seq_decode
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RSEL_W = 2,
    parameter int FN_W   = 4
) (
    input  step_t             step,
    input  logic [DATA_W-1:0] ir,
    output ctl_t              ctl,
    output logic [RSEL_W-1:0] rf_rd_a,
    output logic [RSEL_W-1:0] rf_rd_b,
    output logic [RSEL_W-1:0] rf_wr_sel,
    output logic [FN_W-1:0]   alu_fn
);
    localparam int OPC_LSB = DATA_W - OP_W;
    localparam int RD_LSB  = OPC_LSB - RSEL_W;
    localparam int RS_LSB  = RD_LSB - RSEL_W;
    localparam int RT_LSB  = RS_LSB - RSEL_W;
    localparam int SPARE_W = RT_LSB - FN_W;

    logic [RSEL_W-1:0] f_rd, f_rs, f_rt;
    logic [FN_W-1:0]   f_fn;

    assign f_rd = ir[RD_LSB +: RSEL_W];
    assign f_rs = ir[RS_LSB +: RSEL_W];
    assign f_rt = ir[RT_LSB +: RSEL_W];
    assign f_fn = ir[FN_W-1:0];

    // Spare bits between the register fields and the function code.
    generate
        if (SPARE_W > 0) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^ir[FN_W +: SPARE_W];
        end
    endgenerate

    // Per-step strobe table.
    always_comb begin
        ctl = '0;
        unique case (step)
            S_F0: begin ctl.pc_inc = 1'b1; ctl.ar_pc = 1'b1; end
            S_F1: ctl.rd = 1'b1;
            S_F2: begin ctl.ir_load = 1'b1; ctl.dr_load = 1'b1; end
            S_W0: begin ctl.pc_inc = 1'b1; ctl.ar_pc = 1'b1; end
            S_W1: ctl.rd = 1'b1;
            S_W2: begin ctl.ar_mem = 1'b1; ctl.dr_load = 1'b1; end
            S_L3: ctl.rd = 1'b1;
            S_L4: begin ctl.rf_we = 1'b1; ctl.dr_load = 1'b1; end
            S_S3: begin ctl.wr = 1'b1; ctl.use_ra = 1'b1; end
            S_I0: begin ctl.ar_reg = 1'b1; ctl.use_ra = 1'b1; end
            S_I1: ctl.rd = 1'b1;
            S_I2: begin ctl.rf_we = 1'b1; ctl.dr_load = 1'b1; end
            S_X0: begin ctl.acc_cap = 1'b1; ctl.use_ra = 1'b1; ctl.use_rb = 1'b1; end
            S_X1: begin ctl.rf_we = 1'b1; ctl.wb_alu = 1'b1; end
            default: ctl = '0;
        endcase
    end

    // Register selects and function code, gated to the steps that use them.
    always_comb begin
        rf_rd_a   = ctl.use_ra  ? f_rs : '0;
        rf_rd_b   = ctl.use_rb  ? f_rt : '0;
        rf_wr_sel = ctl.rf_we   ? f_rd : '0;
        alu_fn    = ctl.acc_cap ? f_fn : '0;
    end
endmodule

// File: rtl/seq_regs.sv
// Program counter, address register and instruction register.
// Assumes at most one address-register source is active per cycle.
module seq_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_inc,
    input  logic              ar_pc,
    input  logic              ar_mem,
    input  logic              ar_reg,
    input  logic              ir_load,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] reg_data,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ar,
    output logic [DATA_W-1:0] ir
);
    // Program counter: clear on reset, step by one on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (pc_inc) pc <= pc + 1'b1;
    end

    // Address register: loaded from PC, memory word or a register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ar <= '0;
        else if (ar_pc)  ar <= pc;
        else if (ar_mem) ar <= mem_rdata;
        else if (ar_reg) ar <= reg_data;
    end

    // Instruction register: captures the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)       ir <= '0;
        else if (ir_load) ir <= mem_rdata;
    end
endmodule

// File: rtl/seq_ctrl.sv
// Top of the instruction sequencer. Connects the step machine, decode
// and architectural registers. Assumes memory answers a read strobe one
// cycle later and the register file has a combinational read port A.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RSEL_W = 2,
    parameter int FN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] rf_rdata_a,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              data_ld,
    output logic [RSEL_W-1:0] rf_rd_a,
    output logic [RSEL_W-1:0] rf_rd_b,
    output logic [RSEL_W-1:0] rf_wr_sel,
    output logic              rf_wr_en,
    output logic              wb_alu,
    output logic [FN_W-1:0]   alu_fn,
    output logic              alu_capture,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] ir_out
);
    step_t             step;
    ctl_t              ctl;
    logic [DATA_W-1:0] ar;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] pc;

    seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_op (mem_rdata[DATA_W-1 -: OP_W]),
        .ir_op    (ir[DATA_W-1 -: OP_W]),
        .step     (step)
    );

    seq_decode #(.DATA_W(DATA_W), .RSEL_W(RSEL_W), .FN_W(FN_W)) u_dec (
        .step      (step),
        .ir        (ir),
        .ctl       (ctl),
        .rf_rd_a   (rf_rd_a),
        .rf_rd_b   (rf_rd_b),
        .rf_wr_sel (rf_wr_sel),
        .alu_fn    (alu_fn)
    );

    seq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_inc    (ctl.pc_inc),
        .ar_pc     (ctl.ar_pc),
        .ar_mem    (ctl.ar_mem),
        .ar_reg    (ctl.ar_reg),
        .ir_load   (ctl.ir_load),
        .mem_rdata (mem_rdata),
        .reg_data  (rf_rdata_a),
        .pc        (pc),
        .ar        (ar),
        .ir        (ir)
    );

    // Port drive from decoded strobes and registers.
    always_comb begin
        mem_addr    = ar;
        mem_wdata   = rf_rdata_a;
        mem_rd      = ctl.rd;
        mem_wr      = ctl.wr;
        data_ld     = ctl.dr_load;
        rf_wr_en    = ctl.rf_we;
        wb_alu      = ctl.wb_alu;
        alu_capture = ctl.acc_cap;
        pc_out      = pc;
        ir_out      = ir;
    end
endmodule

// File: rtl/seq_ctrl_chk.sv
// Protocol checker for the sequencer, attached by bind.
module seq_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              data_ld,
    input logic              rf_wr_en,
    input logic              wb_alu,
    input logic              alu_capture,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] ir_out
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_out == '0 && ir_out == '0 && !mem_rd && !mem_wr && !rf_wr_en));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(pc_out)) |-> (pc_out == $past(pc_out) + 1'b1));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    p_rd_to_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> data_ld);

    p_capture_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && data_ld) |-> $past(mem_rd));

    p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    p_we_alu_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rf_wr_en && wb_alu) |-> $past(alu_capture));

    p_we_mem_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rf_wr_en && !wb_alu) |-> $past(mem_rd));
endmodule

bind seq_ctrl seq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .data_ld     (data_ld),
    .rf_wr_en    (rf_wr_en),
    .wb_alu      (wb_alu),
    .alu_capture (alu_capture),
    .pc_out      (pc_out),
    .ir_out      (ir_out)
);

// File: tb/test_seq_ctrl.sv
`timescale 1ns/1ps
module test_seq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] mem_rdata, rf_rdata_a, mem_addr, mem_wdata, pc_out, ir_out;
    logic        mem_rd, mem_wr, data_ld, rf_wr_en, wb_alu, alu_capture;
    logic [1:0]  rf_rd_a, rf_rd_b, rf_wr_sel;
    logic [3:0]  alu_fn;

    // Environment: memory, register file, accumulator.
    logic [15:0] mem [0:63];
    logic [15:0] dp_reg [0:3];
    logic [15:0] acc;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        rg_en = 1'b0;
    logic [1:0]  rg_idx = '0;
    logic [15:0] rg_data = '0;

    // Reference state.
    logic [15:0] mdl_mem [0:63];
    logic [15:0] mdl_reg [0:3];
    logic [15:0] mdl_pc;
    int          n_ins;
    logic [15:0] ins_pc [0:39];
    int          ins_cls [0:39];

    int total = 0, bad = 0;

    localparam int C_LDA = 0, C_LDI = 1, C_STA = 2, C_ALU = 3, C_NOP = 4;

    function automatic logic [15:0] alu_f(input logic [3:0] fn, input logic [15:0] a, input logic [15:0] b);
        case (fn)
            4'd0:    return a + b;
            4'd1:    return a - b;
            4'd2:    return a & b;
            4'd3:    return a | b;
            4'd4:    return a ^ b;
            default: return a;
        endcase
    endfunction

    function automatic int cyc_of(input int cls);
        case (cls)
            C_LDA:   return 8;
            C_LDI:   return 6;
            C_STA:   return 7;
            C_ALU:   return 5;
            default: return 3;
        endcase
    endfunction

    function automatic string tag_of(input int cls);
        case (cls)
            C_LDA:   return "R4";
            C_LDI:   return "R5";
            C_STA:   return "R6";
            C_ALU:   return "R7";
            default: return "R11";
        endcase
    endfunction

    assign mem_rdata_unused_guard = 1'b0;
    logic mem_rdata_unused_guard;

    assign rf_rdata_a = dp_reg[rf_rd_a];

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
        if (alu_capture) acc <= alu_f(alu_fn, dp_reg[rf_rd_a], dp_reg[rf_rd_b]);
        if (rg_en) dp_reg[rg_idx] <= rg_data;
        else if (rf_wr_en) dp_reg[rf_wr_sel] <= wb_alu ? acc : mem_rdata;
    end

    seq_ctrl i_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .rf_rdata_a(rf_rdata_a),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .data_ld(data_ld), .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b), .rf_wr_sel(rf_wr_sel),
        .rf_wr_en(rf_wr_en), .wb_alu(wb_alu), .alu_fn(alu_fn), .alu_capture(alu_capture),
        .pc_out(pc_out), .ir_out(ir_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one memory word (bench and model) while at a falling edge.
    task automatic put(input int addr, input logic [15:0] data);
        ld_en = 1'b1; ld_addr = addr[5:0]; ld_data = data;
        mdl_mem[addr] = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put_reg(input int idx, input logic [15:0] data);
        rg_en = 1'b1; rg_idx = idx[1:0]; rg_data = data;
        mdl_reg[idx] = data;
        @(negedge clk);
        rg_en = 1'b0;
    endtask

    // Build a program; layout per R3: op[15:12] rd[11:10] rs[9:8] rt[7:6] fn[3:0].
    task automatic gen_prog(input int round);
        int p;
        logic [15:0] img [0:63];
        for (int i = 0; i < 64; i++) img[i] = (i < 40) ? 16'h0000 : 16'($urandom());
        p = 0; n_ins = 0;
        while (p < 38 && n_ins < 30) begin
            int cls;
            logic [3:0] op;
            logic [1:0] rd, rs, rt;
            logic [3:0] fn;
            cls = (round == 0 && n_ins < 5) ? n_ins : $urandom_range(0, 4);
            rd = 2'($urandom()); rs = 2'($urandom()); rt = 2'($urandom());
            fn = 4'($urandom_range(0, 7));
            case (cls)
                C_LDA:   op = 4'h1;
                C_LDI:   op = 4'h2;
                C_STA:   op = 4'h3;
                C_ALU:   op = 4'h4;
                default: begin
                    int o;
                    o = $urandom_range(5, 16);
                    op = (o == 16) ? 4'h0 : 4'(o);
                    if (round == 0 && n_ins == 4) op = 4'hF;
                end
            endcase
            ins_pc[n_ins] = 16'(p); ins_cls[n_ins] = cls;
            img[p] = {op, rd, rs, rt, 2'b00, fn};
            p++;
            if (cls == C_LDA || cls == C_STA) begin
                img[p] = 16'($urandom_range(40, 63));
                p++;
            end
            n_ins++;
        end
        for (int i = 0; i < 64; i++) put(i, img[i]);
        for (int i = 0; i < 4; i++) put_reg(i, 16'($urandom()));
    endtask

    task automatic mdl_exec(input int k);
        logic [15:0] w, aw;
        w  = mdl_mem[ins_pc[k][5:0]];
        aw = mdl_mem[6'(ins_pc[k] + 1)];
        case (ins_cls[k])
            C_LDA: begin mdl_reg[w[11:10]] = mdl_mem[aw[5:0]]; mdl_pc = mdl_pc + 2; end
            C_LDI: begin mdl_reg[w[11:10]] = mdl_mem[mdl_reg[w[9:8]][5:0]]; mdl_pc = mdl_pc + 1; end
            C_STA: begin mdl_mem[aw[5:0]] = mdl_reg[w[9:8]]; mdl_pc = mdl_pc + 2; end
            C_ALU: begin mdl_reg[w[11:10]] = alu_f(w[3:0], mdl_reg[w[9:8]], mdl_reg[w[7:6]]); mdl_pc = mdl_pc + 1; end
            default: mdl_pc = mdl_pc + 1;
        endcase
    endtask

    bit done = 1'b0;

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int round = 0; round < 4; round++) begin
            int both, drbad;
            bit prev_rd;
            rst_n = 1'b0;
            @(negedge clk);
            // R1: reset state, including a reset taken mid-sequence.
            chk(pc_out == 16'h0, "R1 pc after reset", pc_out, 16'h0);
            chk(ir_out == 16'h0 && !mem_rd && !mem_wr && !rf_wr_en, "R1 ir/strobes after reset",
                {mem_rd, mem_wr, rf_wr_en, 13'h0} | ir_out, 16'h0);
            gen_prog(round);
            mdl_pc = 16'h0;
            both = 0; drbad = 0; prev_rd = 1'b0;
            rst_n = 1'b1;
            for (int k = 0; k < n_ins; k++) begin
                int nwe, nwr, srcbad, cyc;
                logic [15:0] word;
                nwe = 0; nwr = 0; srcbad = 0;
                cyc = cyc_of(ins_cls[k]);
                word = mdl_mem[ins_pc[k][5:0]];
                for (int c = 0; c < cyc; c++) begin
                    if (rf_wr_en) begin
                        nwe++;
                        if (wb_alu != (ins_cls[k] == C_ALU)) srcbad++;
                    end
                    if (mem_wr) nwr++;
                    if (mem_rd && mem_wr) both++;
                    if (data_ld != prev_rd) drbad++;
                    prev_rd = mem_rd;
                    @(negedge clk);
                end
                mdl_exec(k);
                chk(pc_out == mdl_pc, {tag_of(ins_cls[k]), " pc at boundary"}, pc_out, mdl_pc);
                chk(ir_out == word, "R2 fetched word in ir", ir_out, word);
                chk(nwe == ((ins_cls[k] == C_LDA || ins_cls[k] == C_LDI || ins_cls[k] == C_ALU) ? 1 : 0)
                    && srcbad == 0, {"R8 write count/source ", tag_of(ins_cls[k])},
                    16'(nwe * 16 + srcbad), 16'(((ins_cls[k] == C_STA || ins_cls[k] == C_NOP) ? 0 : 1) * 16));
                chk(nwr == ((ins_cls[k] == C_STA) ? 1 : 0), {"R6 store strobes ", tag_of(ins_cls[k])},
                    16'(nwr), 16'((ins_cls[k] == C_STA) ? 1 : 0));
                for (int r = 0; r < 4; r++)
                    chk(dp_reg[r] === mdl_reg[r], {"R3 ", tag_of(ins_cls[k]), " register"}, dp_reg[r], mdl_reg[r]);
            end
            for (int a = 40; a < 64; a++)
                chk(mem[a] === mdl_mem[a], "R6 data memory", mem[a], mdl_mem[a]);
            chk(both == 0, "R9 read and write together", 16'(both), 16'h0);
            chk(drbad == 0, "R10 capture strobe timing", 16'(drbad), 16'h0);
            // Step into the next fetch so the following reset lands mid-sequence.
            @(negedge clk);
            @(negedge clk);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule